// File: doc/BRIEF.md
# Video Raster Position Counter with Line-Compare Interrupt

This block keeps the beam position of a character-era video controller. It holds a horizontal counter of bus cycles within a line and a vertical counter of lines within a frame. Both advance on a one-per-bus-cycle enable derived from the system clock. A select input picks between two timing variants. The 50 Hz variant has 63 cycles per line and 312 lines per frame. The 60 Hz variant has 65 cycles per line and 263 lines per frame.

Software programs a 9-bit compare line through a small register port. When the beam reaches that line, a raster event is latched in an interrupt status register. Three more event inputs from neighbouring logic share the same status register. A mask register selects which latched events pull the active-low interrupt line.

Two details of timing at the frame wrap are modelled exactly:
- When the frame wraps, the vertical counter holds its last value for one more cycle.
- The line-0 compare is taken one cycle later than the compare for any other line.

Software that stabilises its raster timing depends on both details.

Top module: `raster_irq_unit`

## Requirements
- R1: The cycle counter runs 0..62 when `std_sel`=0 and 0..64 when `std_sel`=1. It advances by one on each clock that has `cyc_en` high. With `cyc_en` low, neither counter changes.
- R2: The line counter advances when the last cycle of a line completes. It wraps to 0 after line 311 (`std_sel`=0) or after line 262 (`std_sel`=1).
- R3: At the frame wrap, the line counter keeps showing the last line number during cycle 0 of the new frame. It shows 0 from cycle 1 onward.
- R4: Reading register offset 0x12 returns bits 7..0 of the line counter. In offset 0x11, bit 7 reads bit 8 of the line counter, and bits 6..0 read back the control bits last written there.
- R5: The 9-bit compare line is written in two parts. Bits 7..0 come from writes to offset 0x12, and bit 8 comes from bit 7 of writes to offset 0x11.
- R6: For a compare line other than 0, bit 0 of the status register (offset 0x19) is set at the end of cycle 0 of that line, so it is first seen in cycle 1. For compare line 0, the bit is set at the end of cycle 1 and first seen in cycle 2.
- R7: Writing a compare value equal to the current line, after that line's compare cycle has passed, does not set the raster status bit during that line.
- R8: Status bits 3..1 are set by pulses on `evt_in[2:0]`. Writing 1 to a status bit clears it, and a set in the same clock wins over the clear. Bit 7 of the status read is the OR of all bits that are both latched and enabled.
- R9: The mask register is at offset 0x1A, bits 3..0. `irq_n` is low exactly while some latched bit is also enabled, and it changes on the same clock edge as the status or the mask.
- R10: After reset, the cycle and line counters read 0. The status, mask and compare registers are 0, and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | One-clock pulse per bus cycle |
| std_sel | input | 1 | 0: 63x312 timing, 1: 65x263 timing |
| evt_in | input | 3 | Event pulses for status bits 3..1 |
| reg_addr | input | 6 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one clock |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cycle_no | output | 7 | Current bus cycle within the line |
| line_no | output | 9 | Current line as reported |
| irq_status | output | 4 | Latched event bits |
| irq_mask | output | 4 | Enable bits |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The counters are driven with a steady enable and with randomly gapped enables. The gapped runs separate true bus-cycle counting from counting raw clocks. Compare lines 100 and 0 are tried in turn, and the cycle in which the status bit first appears tells the normal compare slot from the delayed line-0 slot. Reads of offset 0x12 on both sides of the wrap, in both timing variants, tell a held last line from an immediate reset. Event pulses are also applied with the mask off and on, and together with a clear, to tell masking, clearing and set priority apart.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int PAL_CYC    = 63;
  localparam int PAL_LINES  = 312;
  localparam int NTSC_CYC   = 65;
  localparam int NTSC_LINES = 263;
  localparam int NUM_SRC    = 4;

  localparam logic [5:0] OFS_CTRL = 6'h11;
  localparam logic [5:0] OFS_LINE = 6'h12;
  localparam logic [5:0] OFS_STAT = 6'h19;
  localparam logic [5:0] OFS_MASK = 6'h1A;
endpackage

// File: rtl/raster_timing.sv
module raster_timing
  import raster_pkg::*;
#(
  parameter int CW = 7,
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_en,
  input  logic          std_sel,
  output logic [CW-1:0] cyc_o,
  output logic [LW-1:0] line_o,
  output logic          cmp_slot_o
);
  localparam logic [CW-1:0] LAST_C_A = CW'(PAL_CYC - 1);
  localparam logic [CW-1:0] LAST_C_B = CW'(NTSC_CYC - 1);
  localparam logic [LW-1:0] LAST_L_A = LW'(PAL_LINES - 1);
  localparam logic [LW-1:0] LAST_L_B = LW'(NTSC_LINES - 1);

  logic [CW-1:0] cyc_q;
  logic [LW-1:0] line_q;
  logic          wrap_q;
  logic          end_of_line;
  logic          end_of_frame;

  assign end_of_line  = cyc_q == (std_sel ? LAST_C_B : LAST_C_A);
  assign end_of_frame = line_q == (std_sel ? LAST_L_B : LAST_L_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= '0;
      line_q <= '0;
      wrap_q <= 1'b0;
    end else if (cyc_en) begin
      if (end_of_line) begin
        cyc_q <= '0;
        if (end_of_frame) wrap_q <= 1'b1;
        else              line_q <= line_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
        if (wrap_q && cyc_q == '0) begin
          line_q <= '0;
          wrap_q <= 1'b0;
        end
      end
    end
  end

  // Compare slot: cycle 0 of a normal line, cycle 1 of line 0.
  assign cmp_slot_o = cyc_en &&
    ((cyc_q == CW'(0) && !wrap_q && line_q != '0) ||
     (cyc_q == CW'(1) && line_q == '0));

  assign cyc_o  = cyc_q;
  assign line_o = line_q;
endmodule

// File: rtl/raster_irq_ctrl.sv
module raster_irq_ctrl #(
  parameter int NS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] set_i,
  input  logic          clr_wr_i,
  input  logic          mask_wr_i,
  input  logic [NS-1:0] wdata_i,
  output logic [NS-1:0] stat_o,
  output logic [NS-1:0] mask_o,
  output logic          irq_n_o
);
  logic [NS-1:0] stat_q, stat_d;
  logic [NS-1:0] mask_q, mask_d;
  logic          irq_n_q;

  always_comb begin
    stat_d = stat_q & ~(clr_wr_i ? wdata_i : '0);
    stat_d = stat_d | set_i;
    mask_d = mask_wr_i ? wdata_i : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      mask_q  <= '0;
      irq_n_q <= 1'b1;
    end else begin
      stat_q  <= stat_d;
      mask_q  <= mask_d;
      irq_n_q <= ~|(stat_d & mask_d);
    end
  end

  assign stat_o  = stat_q;
  assign mask_o  = mask_q;
  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter int LW = 9,
  parameter int NS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_i,
  input  logic [LW-1:0] line_i,
  input  logic [NS-1:0] stat_i,
  input  logic [NS-1:0] mask_i,
  output logic [LW-1:0] cmp_o,
  output logic          clr_wr_o,
  output logic          mask_wr_o,
  output logic [DW-1:0] rdata_o
);
  localparam int CTL_W = DW - 1;

  logic [CTL_W-1:0] ctl_q;
  logic [LW-1:0]    cmp_q;
  logic             any_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      cmp_q <= '0;
    end else if (wr_i) begin
      if (addr_i == AW'(OFS_CTRL)) begin
        ctl_q         <= wdata_i[CTL_W-1:0];
        cmp_q[LW-1]   <= wdata_i[DW-1];
      end
      if (addr_i == AW'(OFS_LINE)) cmp_q[LW-2:0] <= wdata_i[LW-2:0];
    end
  end

  assign clr_wr_o  = wr_i && addr_i == AW'(OFS_STAT);
  assign mask_wr_o = wr_i && addr_i == AW'(OFS_MASK);
  assign any_act   = |(stat_i & mask_i);
  assign cmp_o     = cmp_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(OFS_CTRL): rdata_o = {line_i[LW-1], ctl_q};
      AW'(OFS_LINE): rdata_o = line_i[DW-1:0];
      AW'(OFS_STAT): begin
        rdata_o[NS-1:0] = stat_i;
        rdata_o[DW-1]   = any_act;
      end
      AW'(OFS_MASK): rdata_o[NS-1:0] = mask_i;
      default:       rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/raster_irq_unit.sv
module raster_irq_unit
  import raster_pkg::*;
#(
  parameter int CW = 7,
  parameter int LW = 9,
  parameter int AW = 6,
  parameter int DW = 8,
  parameter int NS = NUM_SRC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_en,
  input  logic          std_sel,
  input  logic [NS-2:0] evt_in,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_wr,
  output logic [DW-1:0] reg_rdata,
  output logic [CW-1:0] cycle_no,
  output logic [LW-1:0] line_no,
  output logic [NS-1:0] irq_status,
  output logic [NS-1:0] irq_mask,
  output logic          irq_n
);
  logic          cmp_slot;
  logic [LW-1:0] cmp_line;
  logic          clr_wr;
  logic          mask_wr;
  logic [NS-1:0] set_vec;

  raster_timing #(.CW(CW), .LW(LW)) u_timing (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .std_sel(std_sel),
    .cyc_o(cycle_no), .line_o(line_no), .cmp_slot_o(cmp_slot)
  );

  assign set_vec = {evt_in, cmp_slot && line_no == cmp_line};

  raster_irq_ctrl #(.NS(NS)) u_irq (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_wr_i(clr_wr),
    .mask_wr_i(mask_wr), .wdata_i(reg_wdata[NS-1:0]),
    .stat_o(irq_status), .mask_o(irq_mask), .irq_n_o(irq_n)
  );

  raster_regs #(.AW(AW), .DW(DW), .LW(LW), .NS(NS)) u_regs (
    .clk(clk), .rst(rst), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .wr_i(reg_wr), .line_i(line_no), .stat_i(irq_status),
    .mask_i(irq_mask), .cmp_o(cmp_line), .clr_wr_o(clr_wr),
    .mask_wr_o(mask_wr), .rdata_o(reg_rdata)
  );
endmodule

// File: rtl/raster_irq_chk.sv
module raster_irq_chk #(
  parameter int CW = 7,
  parameter int LW = 9,
  parameter int NS = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cyc_en,
  input logic          std_sel,
  input logic [CW-1:0] cycle_no,
  input logic [LW-1:0] line_no,
  input logic [NS-1:0] irq_status,
  input logic [NS-1:0] irq_mask,
  input logic          irq_n
);
  logic [CW-1:0] last_c;
  assign last_c = std_sel ? CW'(64) : CW'(62);

  assert_cycle_range_R1: assert property (@(posedge clk) disable iff (rst)
    cycle_no <= last_c);

  assert_cycle_step_R1: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && cycle_no != last_c) |=> cycle_no == $past(cycle_no) + 1'b1);

  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !cyc_en |=> ($stable(cycle_no) && $stable(line_no)));

  assert_zero_at_cycle1_R3: assert property (@(posedge clk) disable iff (rst)
    (line_no == '0 && $past(line_no) != '0) |-> cycle_no == CW'(1));

  assert_raster_slot_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_status[0]) |->
      (line_no == '0 ? cycle_no == CW'(2) : cycle_no == CW'(1)));

  assert_irq_line_R9: assert property (@(posedge clk) disable iff (rst)
    irq_n == !(|(irq_status & irq_mask)));
endmodule

bind raster_irq_unit raster_irq_chk #(.CW(CW), .LW(LW), .NS(NS)) u_chk (
  .clk(clk), .rst(rst), .cyc_en(cyc_en), .std_sel(std_sel),
  .cycle_no(cycle_no), .line_no(line_no), .irq_status(irq_status),
  .irq_mask(irq_mask), .irq_n(irq_n)
);

// File: tb/sim_raster_irq_unit.sv
`timescale 1ns/1ps
module sim_raster_irq_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_en = 1'b0;
  logic       std_sel = 1'b0;
  logic [2:0] evt_in = '0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_rdata;
  logic [6:0] cycle_no;
  logic [8:0] line_no;
  logic [3:0] irq_status, irq_mask;
  logic       irq_n;

  always #2 clk = ~clk;

  raster_irq_unit u0 (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .std_sel(std_sel),
    .evt_in(evt_in), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .cycle_no(cycle_no),
    .line_no(line_no), .irq_status(irq_status), .irq_mask(irq_mask),
    .irq_n(irq_n)
  );

  int n_chk = 0, n_fail = 0, mism = 0;
  int m_cyc = 0, m_line = 0;
  bit m_wp = 0;
  int max_c = 0, max_l = 0;

  function automatic int last_cyc();  return std_sel ? 64 : 62;  endfunction
  function automatic int last_line(); return std_sel ? 262 : 311; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input bit en, input logic [2:0] ev = 3'b000);
    cyc_en = en; evt_in = ev;
    @(posedge clk); #1;
    cyc_en = 1'b0; evt_in = '0; reg_wr = 1'b0;
    if (en) begin
      if (m_cyc == last_cyc()) begin
        m_cyc = 0;
        if (m_line == last_line()) m_wp = 1; else m_line++;
      end else begin
        if (m_wp && m_cyc == 0) begin m_line = 0; m_wp = 0; end
        m_cyc++;
      end
    end
    if (int'(cycle_no) != m_cyc || int'(line_no) != m_line) mism++;
    if (int'(cycle_no) > max_c) max_c = int'(cycle_no);
    if (int'(line_no) > max_l) max_l = int'(line_no);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick(1'b0);
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic run_to(input int ln, input int cy);
    while (!(m_line == ln && m_cyc == cy && !m_wp)) tick(1'b1);
  endtask

  task automatic do_reset(input bit sel);
    rst = 1'b1; std_sel = sel;
    repeat (4) @(posedge clk);
    #1; rst = 1'b0;
    m_cyc = 0; m_line = 0; m_wp = 0; mism = 0; max_c = 0; max_l = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    logic [7:0] d;
    bit found;
    int fc, fl;
    void'($urandom(32'd2024));
    do_reset(1'b0);

    // R10 reset state
    chk(cycle_no == 0 && line_no == 0, "R10 counters", int'(cycle_no), 0);
    chk(irq_status == 0 && irq_mask == 0, "R10 status/mask", int'(irq_status), 0);
    chk(irq_n == 1'b1, "R10 irq_n", int'(irq_n), 1);

    // R4 control bits readback
    wr(6'h11, 8'h5A);
    rd(6'h11, d);
    chk(d == 8'h5A, "R4 ctrl readback", int'(d), 'h5A);

    // R5 R6 compare line 100: first seen in cycle 1
    wr(6'h12, 8'd100); wr(6'h11, 8'h00); wr(6'h1A, 8'h01); wr(6'h19, 8'h0F);
    found = 0; fc = -1; fl = -1;
    for (int i = 0; i < 2 * 312 * 63 && !found; i++) begin
      tick(1'b1);
      if (irq_status[0]) begin found = 1; fc = int'(cycle_no); fl = int'(line_no); end
    end
    chk(fl == 100, "R5 compare line", fl, 100);
    chk(fc == 1, "R6 line 100 slot", fc, 1);
    chk(irq_n == 1'b0, "R9 irq asserted", int'(irq_n), 0);
    rd(6'h19, d);
    chk(d[7] == 1'b1, "R8 any bit", int'(d[7]), 1);

    // R8 write-one clear
    wr(6'h19, 8'h01);
    chk(irq_status[0] == 1'b0 && irq_n == 1'b1, "R8 clear", int'(irq_status), 0);

    // R5 R6 compare line 0: first seen in cycle 2
    wr(6'h12, 8'd0);
    found = 0; fc = -1; fl = -1;
    for (int i = 0; i < 2 * 312 * 63 && !found; i++) begin
      tick(1'b1);
      if (irq_status[0]) begin found = 1; fc = int'(cycle_no); fl = int'(line_no); end
    end
    chk(fl == 0, "R6 line 0 compare", fl, 0);
    chk(fc == 2, "R6 line 0 slot one later", fc, 2);
    wr(6'h19, 8'h0F);

    // R7 late compare write does not fire this line
    run_to(50, 5);
    wr(6'h12, 8'd50);
    while (m_cyc != 0) tick(1'b1);
    chk(irq_status[0] == 1'b0, "R7 late write", int'(irq_status[0]), 0);

    // R2 R3 R4 reads around wrap, 63x312
    run_to(311, 62);
    rd(6'h12, d); chk(d == 8'h37, "R4 line low at 311", int'(d), 'h37);
    rd(6'h11, d); chk(d[7] == 1'b1, "R4 line bit8 at 311", int'(d[7]), 1);
    tick(1'b1);
    rd(6'h12, d); chk(d == 8'h37 && cycle_no == 0, "R3 held in cycle 0", int'(d), 'h37);
    tick(1'b1);
    rd(6'h12, d); chk(d == 8'h00 && cycle_no == 1, "R3 zero in cycle 1", int'(d), 0);
    rd(6'h11, d); chk(d[7] == 1'b0, "R4 bit8 after wrap", int'(d[7]), 0);
    chk(max_c == 62 && max_l == 311, "R2 63x312 extent", max_c * 1000 + max_l, 62311);
    chk(mism == 0, "R1 R2 model track 63x312", mism, 0);

    // R8 R9 masking, events, set-over-clear
    wr(6'h1A, 8'h00); wr(6'h19, 8'h0F);
    tick(1'b0, 3'b010);
    chk(irq_status[2] == 1'b1 && irq_n == 1'b1, "R9 masked event", int'(irq_n), 1);
    rd(6'h19, d); chk(d[7] == 1'b0, "R8 any masked", int'(d[7]), 0);
    wr(6'h1A, 8'h04);
    chk(irq_n == 1'b0, "R9 unmask", int'(irq_n), 0);
    reg_addr = 6'h19; reg_wdata = 8'h02; reg_wr = 1'b1;
    tick(1'b0, 3'b001);
    chk(irq_status[1] == 1'b1, "R8 set wins", int'(irq_status[1]), 1);

    // R1 R2 R3 65x263
    do_reset(1'b1);
    run_to(262, 64);
    rd(6'h12, d); chk(d == 8'h06, "R4 line low at 262", int'(d), 6);
    tick(1'b1);
    chk(line_no == 262 && cycle_no == 0, "R3 held 65x263", int'(line_no), 262);
    tick(1'b1);
    chk(line_no == 0 && cycle_no == 1, "R3 zero 65x263", int'(line_no), 0);
    chk(max_c == 64 && max_l == 262, "R2 65x263 extent", max_c * 1000 + max_l, 64262);

    // R1 random gapped enables
    for (int i = 0; i < 6000; i++) tick(($urandom % 3) != 0);
    chk(mism == 0, "R1 gapped enable track", mism, 0);

    summary();
  end
endmodule